// File: doc/BRIEF.md
# Flash Program Command Decoder

This block models the write-command state machine of a parallel NOR flash device together with a small storage array. It watches bus write cycles (address, data, write strobe) and recognizes two ways of asking for a program operation. The first is the full four-write sequence of two unlock writes, a set-up write and an address/data write. The second is a fast mode, entered once, in which each program needs only a command write and an address/data write. A recognized request starts an internal program operation that lasts a fixed number of clock cycles. During that time the block reports busy on a ready output and answers reads with polling status instead of array data.

Programming follows flash rules: a bit can be cleared but never set, so the stored byte becomes the old value ANDed with the written value. The synchronous active-low reset acts as the device's hardware reset. It aborts any operation, returns the command machine to read mode and, as a model convenience, restores the array to the erased (all ones) state. Erase, sector protection, identification reads and bus width switching are not part of this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes AAh to address 555h, 55h to address 2AAh and A0h to address 555h, followed by any fourth write, start a program of the fourth write's data at the fourth write's address. `ready` goes low on the clock edge that takes the fourth write.
- R2: A write that does not match the expected unlock or set-up cycle returns the machine to read mode. That write is not taken as the start of a new sequence.
- R3: `ready` stays low for exactly PROG_CYCLES clock cycles. The new array value is readable in the first cycle in which `ready` is high again.
- R4: A program stores old AND new, so a bit that is already 0 stays 0 even when the written data has a 1 there.
- R5: All writes are ignored while `ready` is low, both by the command machine and by the array.
- R6: While `rst_n` is low, `ready` goes high on the next edge, any running program is dropped, the machine returns to read mode and every array byte becomes FFh.
- R7: While `ready` is low, `rdata[7]` is the complement of bit 7 of the data being programmed. `rdata[6]` starts at 0 and inverts after every clock edge on which `rd_en` is high. `rdata[5:0]` is zero.
- R8: The two unlock writes followed by 20h to address 555h enter fast mode without programming anything.
- R9: In fast mode, a write of A0h (any address) followed by any write programs that write's data at its address. The machine then stays in fast mode, so this can repeat at any addresses in any order.
- R10: In fast mode, a write of 90h followed by a write of 00h, at any addresses, returns to read mode. After that, an A0h write no longer arms a program.
- R11: In fast mode, a first write with data other than A0h or 90h is ignored. A 90h followed by data other than 00h drops back to fast mode idle.
- R12: When `ready` is high, `rdata` shows the array byte selected by the low address bits, combinationally and without any need for `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe; advances the toggle bit while busy |
| addr | input | ADDR_W | Bus address; low bits select the array byte |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Array byte when ready, polling status when busy |
| ready | output | 1 | High when idle, low while a program runs |

## Verification
The checker watches, on every cycle, the things that can be seen from timing alone. It checks that a busy period begins only on a write, that it lasts exactly PROG_CYCLES cycles, and that the command mode does not move while busy. It also checks that DQ7 holds steady through an operation, that DQ6 inverts after each busy read, and that reset forces idle read mode. Only the bench's scenarios can show which write sequences are accepted or rejected. The same holds for the AND rule on stored data, for fast mode staying active across several programs, and for its exit. These are covered by a behavioural model that tracks mode, array and status and is compared with the outputs every cycle.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command constants for the flash program command decoder.
package flash_cmd_pkg;

    // Width of the address bits that take part in command matching.
    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A  = 11'h555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B  = 11'h2AA;
    localparam logic [7:0]        KEY_DATA_A  = 8'hAA;
    localparam logic [7:0]        KEY_DATA_B  = 8'h55;
    localparam logic [7:0]        CMD_PROGRAM = 8'hA0;
    localparam logic [7:0]        CMD_FAST    = 8'h20;
    localparam logic [7:0]        CMD_EXIT_1  = 8'h90;
    localparam logic [7:0]        CMD_EXIT_2  = 8'h00;

    // Command machine modes.
    typedef enum logic [2:0] {
        M_READ,      // idle, array reads
        M_KEY1,      // first unlock write seen
        M_KEY2,      // second unlock write seen
        M_SETUP,     // program set-up seen, next write is address/data
        M_FAST,      // fast mode idle
        M_FAST_PGM,  // fast mode, program command seen
        M_FAST_EXIT  // fast mode, first exit write seen
    } fcd_mode_e;

endpackage

// File: rtl/fcd_seq.sv
// Command sequence tracker.
// Decodes bus writes into mode changes and raises a one-cycle launch when
// an address/data write completes a program request.
// Assumes: busy comes from the program timer; writes while busy are dropped.
module fcd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    output fcd_mode_e         mode,
    output logic              launch
);

    logic [CMD_AW-1:0] key_addr;
    logic              take;
    fcd_mode_e         mode_nx;

    assign key_addr = addr[CMD_AW-1:0];
    assign take     = wr_en && !busy;
    assign launch   = take && (mode == M_SETUP || mode == M_FAST_PGM);

    // Next mode from the current mode and an accepted write.
    always_comb begin
        mode_nx = mode;
        if (take) begin
            unique case (mode)
                M_READ:
                    if (key_addr == KEY_ADDR_A && wdata == KEY_DATA_A) mode_nx = M_KEY1;
                M_KEY1:
                    mode_nx = (key_addr == KEY_ADDR_B && wdata == KEY_DATA_B) ? M_KEY2 : M_READ;
                M_KEY2: begin
                    mode_nx = M_READ;
                    if (key_addr == KEY_ADDR_A && wdata == CMD_PROGRAM) mode_nx = M_SETUP;
                    if (key_addr == KEY_ADDR_A && wdata == CMD_FAST)    mode_nx = M_FAST;
                end
                M_SETUP:     mode_nx = M_READ;
                M_FAST: begin
                    if (wdata == CMD_PROGRAM) mode_nx = M_FAST_PGM;
                    if (wdata == CMD_EXIT_1)  mode_nx = M_FAST_EXIT;
                end
                M_FAST_PGM:  mode_nx = M_FAST;
                M_FAST_EXIT: mode_nx = (wdata == CMD_EXIT_2) ? M_READ : M_FAST;
                default:     mode_nx = M_READ;
            endcase
        end
    end

    // Mode register with hardware reset to read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= M_READ;
        else        mode <= mode_nx;
    end

endmodule

// File: rtl/fcd_timer.sv
// Program operation timer.
// Holds the target of a launched program for PROG_CYCLES cycles, then
// issues a one-cycle commit. Also keeps the polling toggle bit.
// Assumes: launch never arrives while busy (the sequencer gates it).
module fcd_timer #(
    parameter int PROG_CYCLES = 8,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [IDX_W-1:0] launch_idx,
    input  logic [7:0]       launch_data,
    input  logic             rd_en,
    output logic             busy,
    output logic             commit,
    output logic [IDX_W-1:0] tgt_idx,
    output logic [7:0]       tgt_data,
    output logic             toggle
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    assign commit = busy && (remain == '0);

    // Busy window countdown and target capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain   <= '0;
            tgt_idx  <= '0;
            tgt_data <= '0;
        end else if (launch) begin
            busy     <= 1'b1;
            remain   <= CW'(PROG_CYCLES - 1);
            tgt_idx  <= launch_idx;
            tgt_data <= launch_data;
        end else if (busy) begin
            if (remain == '0) busy   <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // Toggle bit: cleared at launch, inverted by each read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)              toggle <= 1'b0;
        else if (launch)         toggle <= 1'b0;
        else if (busy && rd_en)  toggle <= ~toggle;
    end

endmodule

// File: rtl/fcd_array.sv
// Small programmable storage array.
// A commit can only clear bits: the cell takes old AND new.
// Assumes: reset models an erased array (all ones).
module fcd_array #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [IDX_W-1:0] cmt_idx,
    input  logic [7:0]       cmt_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] cells [DEPTH];

    // Erase on reset, bit-clearing update on commit.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                cells[i] <= 8'hFF;
            else if (commit && cmt_idx == IDX_W'(i))
                cells[i] <= cells[i] & cmt_data;
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/flash_cmd_decoder.sv
// Flash program command decoder, top level.
// Ties the sequence tracker, program timer and storage array together and
// muxes array data or polling status onto the read bus.
// Assumes: ADDR_W >= 11 and ARR_DEPTH a power of two no larger than 2**ADDR_W.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int ARR_DEPTH   = 16,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ready
);

    localparam int IDX_W = $clog2(ARR_DEPTH);

    fcd_mode_e        mode;
    logic             launch;
    logic             busy;
    logic             commit;
    logic [IDX_W-1:0] tgt_idx;
    logic [7:0]       tgt_data;
    logic             toggle;
    logic [7:0]       arr_data;

    fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .busy   (busy),
        .mode   (mode),
        .launch (launch)
    );

    fcd_timer #(.PROG_CYCLES(PROG_CYCLES), .IDX_W(IDX_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_idx  (addr[IDX_W-1:0]),
        .launch_data (wdata),
        .rd_en       (rd_en),
        .busy        (busy),
        .commit      (commit),
        .tgt_idx     (tgt_idx),
        .tgt_data    (tgt_data),
        .toggle      (toggle)
    );

    fcd_array #(.DEPTH(ARR_DEPTH), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .cmt_idx  (tgt_idx),
        .cmt_data (tgt_data),
        .rd_idx   (addr[IDX_W-1:0]),
        .rd_data  (arr_data)
    );

    // Read bus: polling status while busy, array byte otherwise.
    always_comb begin
        if (busy) rdata = {~tgt_data[7], toggle, 6'b0};
        else      rdata = arr_data;
    end

    assign ready = !busy;

endmodule

// File: rtl/fcd_checker.sv
// Timing checker for the flash program command decoder, bound to the top.
// Watches ports and the command mode only.
module fcd_checker
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       ready,
    input logic [7:0] rdata,
    input fcd_mode_e  mode
);

    logic [31:0] low_run;

    // Length of the current low stretch of ready.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_run <= '0;
        else if (!ready) low_run <= low_run + 1;
        else            low_run <= '0;
    end

    // R1: a busy period can only start from a bus write.
    a_r1_launch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wr_en));

    // R3: a completed busy period is exactly PROG_CYCLES long.
    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(rst_n)) |-> (low_run == 32'(PROG_CYCLES)));

    // R3: busy never runs past PROG_CYCLES.
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (low_run < 32'(PROG_CYCLES)));

    // R5: the command mode does not move while busy.
    a_r5_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(mode));

    // R6: reset forces idle read mode on the next edge.
    a_r6_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ready && mode == M_READ));

    // R7: DQ7 holds steady through one operation.
    a_r7_dq7_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> (rdata[7] == $past(rdata[7])));

    // R7: DQ6 inverts after each busy read.
    a_r7_dq6_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready && rd_en)) |-> (rdata[6] != $past(rdata[6])));

    // R7: low status bits are zero while busy.
    a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (rdata[5:0] == 6'b0));

endmodule

bind flash_cmd_decoder fcd_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .ready (ready),
    .rdata (rdata),
    .mode  (mode)
);

// File: tb/sim_flash_cmd_decoder.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module sim_flash_cmd_decoder;

    localparam int PROG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready;

    int    vectors = 0;
    int    errors  = 0;
    string req     = "R6";
    bit    done    = 0;

    // Reference model state.
    int         md = 0;  // 0 read,1 key1,2 key2,3 setup,4 fast,5 fast pgm,6 fast exit
    int         left = 0;
    bit         tog = 0;
    logic [7:0] mem [16];
    logic [3:0] pidx = '0;
    logic [7:0] pdat = '0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(11), .ARR_DEPTH(16), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    task automatic start_prog();
        left = PROG; pidx = addr[3:0]; pdat = wdata; tog = 0;
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            md = 0; left = 0; tog = 0;
            for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        end else if (left > 0) begin
            if (rd_en) tog = ~tog;
            left--;
            if (left == 0) mem[pidx] = mem[pidx] & pdat;
        end else if (wr_en) begin
            case (md)
                0: if (addr == 11'h555 && wdata == 8'hAA) md = 1;
                1: md = (addr == 11'h2AA && wdata == 8'h55) ? 2 : 0;
                2: if (addr == 11'h555 && wdata == 8'hA0) md = 3;
                   else if (addr == 11'h555 && wdata == 8'h20) md = 4;
                   else md = 0;
                3: begin start_prog(); md = 0; end
                4: if (wdata == 8'hA0) md = 5; else if (wdata == 8'h90) md = 6;
                5: begin start_prog(); md = 4; end
                6: md = (wdata == 8'h00) ? 0 : 4;
                default: md = 0;
            endcase
        end
    end

    task automatic compare();
        logic       e_rdy;
        logic [7:0] e_rd;
        e_rdy = (left == 0);
        e_rd  = e_rdy ? mem[addr[3:0]] : {~pdat[7], tog, 6'b0};
        vectors++;
        if (ready !== e_rdy || rdata !== e_rd) begin
            errors++;
            $display("FAIL %s: ready %b rdata %h, expected ready %b rdata %h",
                     req, ready, rdata, e_rdy, e_rd);
        end
    endtask

    task automatic step(input bit we, input logic [10:0] a, input logic [7:0] d, input bit re);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; rd_en = re;
        #1 compare();
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        step(1, a, d, 0);
    endtask

    task automatic rd(input logic [10:0] a);
        step(0, a, 8'h00, 1);
    endtask

    task automatic poll_done();
        for (int k = 0; k < 40 && left > 0; k++) rd(11'h000);
        rd(11'h000);
    endtask

    task automatic std_prog(input logic [10:0] a, input logic [7:0] d);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
    endtask

    task automatic read_all();
        for (int i = 0; i < 16; i++) rd(11'(i));
    endtask

    initial begin
        // R6: reset state
        req = "R6";
        step(0, 0, 0, 0); step(0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        read_all();

        // R12: idle reads with and without rd_en
        req = "R12";
        step(0, 11'h7F3, 0, 0); rd(11'h009);

        // R1, R7, R3: standard program with polling
        req = "R1";  std_prog(11'h003, 8'h5A);
        req = "R7";  rd(11'h003); rd(11'h003); step(0, 11'h003, 0, 0); rd(11'h003);
        req = "R3";  poll_done(); rd(11'h003);

        // R4: bits only clear
        req = "R4";
        std_prog(11'h003, 8'hFF); poll_done(); rd(11'h003);
        std_prog(11'h003, 8'h0F); poll_done(); rd(11'h003);

        // R5: writes during busy are dropped
        req = "R5";
        std_prog(11'h00C, 8'h81);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h00C, 8'h00);
        poll_done(); wr(11'h00C, 8'h00); rd(11'h00C);

        // R2: mismatching cycles return to read
        req = "R2";
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80); wr(11'h001, 8'h00); rd(11'h001);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h11); wr(11'h555, 8'hA0); wr(11'h001, 8'h00); rd(11'h001);
        wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h001, 8'h00); rd(11'h001);
        wr(11'h555, 8'hAA); wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
        wr(11'h001, 8'h00); rd(11'h001);

        // R8, R9: fast mode entry and repeated programs in any order
        req = "R8";
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h20); read_all();
        req = "R9";
        wr(11'h123, 8'hA0); wr(11'h00F, 8'h3C); poll_done();
        wr(11'h000, 8'hA0); wr(11'h000, 8'hE7); poll_done();
        wr(11'h7FF, 8'hA0); wr(11'h408, 8'h12); poll_done();
        read_all();

        // R11: stray writes in fast mode
        req = "R11";
        wr(11'h555, 8'h55); wr(11'h005, 8'h00); rd(11'h005);
        wr(11'h000, 8'h90); wr(11'h000, 8'h12); wr(11'h000, 8'hA0); wr(11'h006, 8'h66); poll_done();
        rd(11'h006);

        // R10: fast mode exit
        req = "R10";
        wr(11'h3A1, 8'h90); wr(11'h0F0, 8'h00); wr(11'h000, 8'hA0); wr(11'h00A, 8'h00);
        rd(11'h00A); rd(11'h00A);

        // R6: reset aborts a running program
        req = "R6";
        std_prog(11'h002, 8'h00); rd(11'h002); rd(11'h002);
        @(negedge clk); rst_n = 1'b0; #1 compare();
        step(0, 11'h002, 0, 0);
        @(negedge clk); rst_n = 1'b1; #1 compare();
        read_all();
        std_prog(11'h002, 8'h00); poll_done(); rd(11'h002);

        step(0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule